// File: doc/BRIEF.md
# Interrupt Wakeup and Priority Resolver

This block watches 28 interrupt request lines, each carrying a 3-bit priority level supplied by configuration logic elsewhere in the chip. Every cycle it selects one winning request. The highest non-zero level wins. When two or more requests share the top level, the winner is decided by a fixed source order. The winner's index, its level and a valid flag are registered outputs.

It also produces a registered wakeup for the core while the core sits in a low-power mode. A 32-bit wakeup-enable register selects the sources allowed to wake the core. Software writes it with a single-cycle strobe and reads it back combinationally. In the deeper STOP mode, only the six external pin sources can wake the core. An enabled internal source cannot.

Source index `s` runs from 0 (first in the fixed order) to 27 (last). Index `s` maps to enable-register bit `31 - s`. The external pin sources are indices 0, 1, 2, 3, 25 and 26.

Top module: `irq_wake_arbiter`

## Requirements
- R1: After reset, the enable register reads 0x00000000, and `win_vld_o`, `win_idx_o`, `win_lvl_o` and `wake_o` are all zero.
- R2: A write with `wr_en_i` high loads bit `31 - s` of `wr_data_i` as the enable of source `s`. From the next clock on, `rd_data_o` returns that value at the same bit position.
- R3: Bits 3..0 of `rd_data_o` always read zero. A write to those bits has no effect.
- R4: A request whose level is 0 never takes part in arbitration. When no request has a non-zero level, `win_vld_o` is 0 and `win_idx_o` and `win_lvl_o` are 0.
- R5: Among active requests with a non-zero level, the one with the highest level wins. `win_lvl_o` reports that level.
- R6: When several active requests share the highest level, the one with the lowest source index (the higher register bit) wins.
- R7: When `pwr_mode_i` is 0 (RUN) or 3 (unused), `wake_o` is 0.
- R8: When `pwr_mode_i` is 1 (SLEEP), `wake_o` is 1 exactly when some active request has its enable bit set. The request's level does not matter.
- R9: When `pwr_mode_i` is 2 (STOP), `wake_o` is 1 exactly when some active request that is both enabled and one of the external sources (indices 0-3, 25, 26) is present.
- R10: All four result outputs are registered. They reflect the inputs one clock edge after the inputs are applied, and do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 28 | Request lines, bit s = source s |
| lvl_i | input | 84 | Priority levels, source s at bits [3s+2:3s] |
| pwr_mode_i | input | 2 | 0 RUN, 1 SLEEP, 2 STOP |
| wr_en_i | input | 1 | Single-cycle write strobe for the enable register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read-back of the enable register |
| win_idx_o | output | 5 | Registered winning source index |
| win_lvl_o | output | 3 | Registered winning level |
| win_vld_o | output | 1 | Registered winner-valid flag |
| wake_o | output | 1 | Registered wakeup request |

## Verification
The bench builds the block with its default parameters: 28 sources, 3-bit levels and the default external-source mask. At this width, every source position and every register bit is covered, along with the both ends of the fixed order (index 0 against index 27). Seven distinct non-zero levels make ties at any level reachable. Random stimulus mixes dense and sparse request patterns with all four mode codes, which exercises the STOP filter against internal sources that are enabled.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_STOP  = 2'd2,
    PM_RSVD  = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/wake_en_reg.sv
module wake_en_reg #(
  parameter int N_SRC = 28,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [N_SRC-1:0] en_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int PAD_W = REG_W - N_SRC;

  logic [N_SRC-1:0] en_q;

  // source s lives at register bit REG_W-1-s
  for (genvar s = 0; s < N_SRC; s++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      en_q[s] <= 1'b0;
      else if (wr_en_i) en_q[s] <= wr_data_i[REG_W-1-s];
    end
    assign rd_data_o[REG_W-1-s] = en_q[s];
  end

  if (PAD_W > 0) begin : g_pad
    assign rd_data_o[PAD_W-1:0] = '0;
  end

  assign en_o = en_q;
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N_SRC = 28,
  parameter int LVL_W = 3,
  parameter int IDX_W = 5
) (
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  output logic [IDX_W-1:0]       idx_o,
  output logic [LVL_W-1:0]       lvl_o,
  output logic                   vld_o
);
  logic [N_SRC-1:0][LVL_W-1:0] eff_lvl;

  // level 0 or idle request counts as absent
  for (genvar s = 0; s < N_SRC; s++) begin : g_eff
    assign eff_lvl[s] = req_i[s] ? lvl_i[s*LVL_W +: LVL_W] : '0;
  end

  // scan from last to first; >= lets lower index take ties
  always_comb begin
    idx_o = '0;
    lvl_o = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (eff_lvl[s] != '0 && eff_lvl[s] >= lvl_o) begin
        idx_o = IDX_W'(s);
        lvl_o = eff_lvl[s];
      end
    end
    vld_o = (lvl_o != '0);
  end
endmodule

// File: rtl/wake_qual.sv
module wake_qual
  import irq_wake_pkg::*;
#(
  parameter int               N_SRC    = 28,
  parameter logic [N_SRC-1:0] EXT_MASK = 28'h600000F
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [1:0]       pwr_mode_i,
  output logic             wake_o
);
  logic [N_SRC-1:0] armed;

  assign armed = req_i & en_i;

  always_comb begin
    unique case (pwr_mode_e'(pwr_mode_i))
      PM_SLEEP: wake_o = |armed;
      PM_STOP:  wake_o = |(armed & EXT_MASK);
      default:  wake_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_wake_arbiter.sv
module irq_wake_arbiter
  import irq_wake_pkg::*;
#(
  parameter int               N_SRC    = 28,
  parameter int               LVL_W    = 3,
  parameter logic [N_SRC-1:0] EXT_MASK = 28'h600000F,
  localparam int              IDX_W    = $clog2(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  input  logic [1:0]             pwr_mode_i,
  input  logic                   wr_en_i,
  input  logic [REG_W-1:0]       wr_data_i,
  output logic [REG_W-1:0]       rd_data_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [LVL_W-1:0]       win_lvl_o,
  output logic                   win_vld_o,
  output logic                   wake_o
);
  logic [N_SRC-1:0] en;
  logic [IDX_W-1:0] pick_idx;
  logic [LVL_W-1:0] pick_lvl;
  logic             pick_vld;
  logic             wake_d;

  wake_en_reg #(.N_SRC(N_SRC), .REG_W(REG_W)) i_en_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .en_o      (en),
    .rd_data_o (rd_data_o)
  );

  prio_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) i_pick (
    .req_i (req_i),
    .lvl_i (lvl_i),
    .idx_o (pick_idx),
    .lvl_o (pick_lvl),
    .vld_o (pick_vld)
  );

  wake_qual #(.N_SRC(N_SRC), .EXT_MASK(EXT_MASK)) i_qual (
    .req_i      (req_i),
    .en_i       (en),
    .pwr_mode_i (pwr_mode_i),
    .wake_o     (wake_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_idx_o <= '0;
      win_lvl_o <= '0;
      win_vld_o <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      win_idx_o <= pick_idx;
      win_lvl_o <= pick_lvl;
      win_vld_o <= pick_vld;
      wake_o    <= wake_d;
    end
  end
endmodule

// File: rtl/irq_wake_chk.sv
module irq_wake_chk #(
  parameter int               N_SRC    = 28,
  parameter int               LVL_W    = 3,
  parameter int               IDX_W    = 5,
  parameter logic [N_SRC-1:0] EXT_MASK = 28'h600000F
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic [1:0]       pwr_mode_i,
  input logic [31:0]      rd_data_o,
  input logic [IDX_W-1:0] win_idx_o,
  input logic [LVL_W-1:0] win_lvl_o,
  input logic             win_vld_o,
  input logic             wake_o
);
  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[3:0] == 4'h0);

  // R4
  no_req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> !win_vld_o);

  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_vld_o |-> (win_idx_o == '0 && win_lvl_o == '0));

  // R5
  vld_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> win_lvl_o != '0);

  // R7
  run_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_i == 2'd0 || pwr_mode_i == 2'd3) |=> !wake_o);

  // R8
  sleep_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_i == 2'd1 && req_i == '0) |=> !wake_o);

  // R9
  stop_ext_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_i == 2'd2 && (req_i & EXT_MASK) == '0) |=> !wake_o);
endmodule

bind irq_wake_arbiter irq_wake_chk #(
  .N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W), .EXT_MASK(EXT_MASK)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .pwr_mode_i (pwr_mode_i),
  .rd_data_o  (rd_data_o),
  .win_idx_o  (win_idx_o),
  .win_lvl_o  (win_lvl_o),
  .win_vld_o  (win_vld_o),
  .wake_o     (wake_o)
);

// File: tb/test_irq_wake_arbiter.sv
`timescale 1ns/1ps
module test_irq_wake_arbiter;
  localparam int N  = 28;
  localparam int LW = 3;
  localparam logic [N-1:0] EXT = 28'h600000F;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    req_i = '0;
  logic [N*LW-1:0] lvl_i = '0;
  logic [1:0]      pwr_mode_i = 2'd0;
  logic            wr_en_i = 1'b0;
  logic [31:0]     wr_data_i = '0;
  logic [31:0]     rd_data_o;
  logic [4:0]      win_idx_o;
  logic [2:0]      win_lvl_o;
  logic            win_vld_o;
  logic            wake_o;

  logic [N-1:0] en_m = '0;
  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  irq_wake_arbiter i_irq_wake_arbiter (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] model_win(input logic [N-1:0] r, input logic [N*LW-1:0] l);
    logic [4:0] bi = '0;
    logic [2:0] bl = '0;
    for (int s = 0; s < N; s++) begin
      if (r[s] && l[s*LW +: LW] > bl) begin
        bl = l[s*LW +: LW];
        bi = 5'(s);
      end
    end
    return {bl != 0, bl, bi};
  endfunction

  function automatic logic model_wake(input logic [N-1:0] r, input logic [1:0] m);
    if (m == 2'd1) return |(r & en_m);
    if (m == 2'd2) return |(r & en_m & EXT);
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_rd();
    logic [31:0] v = '0;
    for (int s = 0; s < N; s++) v[31-s] = en_m[s];
    return v;
  endfunction

  task automatic wr_reg(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    for (int s = 0; s < N; s++) en_m[s] = d[31-s];
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(rd_data_o == model_rd(), "R2/R3 readback", rd_data_o, model_rd());
  endtask

  task automatic apply(input logic [N-1:0] r, input logic [N*LW-1:0] l, input logic [1:0] m, input string tag);
    logic [8:0] w;
    logic       wk;
    @(negedge clk_i);
    req_i = r;
    lvl_i = l;
    pwr_mode_i = m;
    w  = model_win(r, l);
    wk = model_wake(r, m);
    @(negedge clk_i);
    chk({win_vld_o, win_lvl_o, win_idx_o} == w, tag, {win_vld_o, win_lvl_o, win_idx_o}, w);
    chk(wake_o == wk, tag, wake_o, wk);
  endtask

  function automatic logic [N*LW-1:0] one_lvl(input int s, input logic [2:0] v);
    logic [N*LW-1:0] l = '0;
    l[s*LW +: LW] = v;
    return l;
  endfunction

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N*LW-1:0] l;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R1
    chk(rd_data_o == 32'h0, "R1 enables", rd_data_o, 0);
    chk({win_vld_o, win_lvl_o, win_idx_o, wake_o} == '0, "R1 outputs",
        {win_vld_o, win_lvl_o, win_idx_o, wake_o}, 0);
    rst_ni = 1'b1;

    // R2 R3
    wr_reg(32'hFFFF_FFFF);
    chk(rd_data_o == 32'hFFFF_FFF0, "R3 rsvd", rd_data_o, 32'hFFFF_FFF0);
    wr_reg(32'h8000_000F);
    chk(rd_data_o == 32'h8000_0000, "R2 src0 bit31", rd_data_o, 32'h8000_0000);

    // R4: all requests at level 0
    apply('1, '0, 2'd0, "R4 masked");
    chk(win_vld_o == 1'b0, "R4 vld", win_vld_o, 0);

    // R5: higher level beats earlier order
    l = one_lvl(20, 3'd5) | one_lvl(3, 3'd2);
    apply((N'(1) << 20) | (N'(1) << 3), l, 2'd0, "R5 level");
    chk(win_idx_o == 5'd20 && win_lvl_o == 3'd5, "R5 idx", win_idx_o, 20);

    // R6: tie at level 4
    l = one_lvl(27, 3'd4) | one_lvl(10, 3'd4) | one_lvl(5, 3'd4);
    apply((N'(1) << 27) | (N'(1) << 10) | (N'(1) << 5), l, 2'd0, "R6 tie");
    chk(win_idx_o == 5'd5, "R6 idx", win_idx_o, 5);
    l = one_lvl(27, 3'd7) | one_lvl(0, 3'd7);
    apply((N'(1) << 27) | N'(1), l, 2'd0, "R6 ends");
    chk(win_idx_o == 5'd0, "R6 idx0", win_idx_o, 0);

    // R7
    wr_reg(32'hFFFF_FFF0);
    apply('1, '1, 2'd0, "R7 run");
    chk(wake_o == 1'b0, "R7 run wake", wake_o, 0);
    apply('1, '1, 2'd3, "R7 rsvd mode");
    chk(wake_o == 1'b0, "R7 mode3 wake", wake_o, 0);

    // R8: only source 10 enabled (bit 21), level ignored
    wr_reg(32'h0020_0000);
    apply(N'(1) << 10, '0, 2'd1, "R8 sleep");
    chk(wake_o == 1'b1, "R8 wake lvl0", wake_o, 1);
    apply(N'(1) << 11, one_lvl(11, 3'd7), 2'd1, "R8 sleep");
    chk(wake_o == 1'b0, "R8 disabled", wake_o, 0);

    // R9: internal enabled source blocked in STOP, external passes
    wr_reg(32'hFFFF_FFF0);
    apply(N'(1) << 10, one_lvl(10, 3'd1), 2'd2, "R9 stop int");
    chk(wake_o == 1'b0, "R9 int blocked", wake_o, 0);
    apply(N'(1) << 25, '0, 2'd2, "R9 stop ext");
    chk(wake_o == 1'b1, "R9 ext wakes", wake_o, 1);
    wr_reg(32'hFFFF_FFF0 & ~(32'h1 << 6));
    apply(N'(1) << 25, '0, 2'd2, "R9 ext disabled");
    chk(wake_o == 1'b0, "R9 ext off", wake_o, 0);

    // R10: no change before the edge
    apply('0, '0, 2'd1, "R10 idle");
    @(negedge clk_i);
    req_i = N'(1) << 7;
    lvl_i = one_lvl(7, 3'd3);
    #1;
    chk(win_vld_o == 1'b0 && wake_o == 1'b0, "R10 pre-edge", {win_vld_o, wake_o}, 0);
    @(negedge clk_i);
    chk(win_vld_o && win_idx_o == 5'd7 && wake_o, "R10 post-edge", {win_vld_o, win_idx_o, wake_o}, {1'b1, 5'd7, 1'b1});

    // random mix, R5 R6 R8 R9
    for (int it = 0; it < 400; it++) begin
      logic [N-1:0] r;
      logic [N*LW-1:0] lr;
      if ($urandom_range(0, 7) == 0) wr_reg($urandom());
      r = N'($urandom());
      if ($urandom_range(0, 1) == 1) r = r & N'($urandom()) & N'($urandom());
      for (int s = 0; s < N; s++) lr[s*LW +: LW] = 3'($urandom_range(0, 7));
      apply(r, lr, 2'($urandom_range(0, 3)), "R5/R6/R8/R9 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule